// File: doc/BRIEF.md
# Paging Decoder Interrupt Status Unit

This unit gathers event indications from a paging decoder core into one read-clear status byte and drives a single interrupt line whose active level is chosen by an input. Some events raise the interrupt straight away. Others are held back until the receiver is switched off. Call data that is ready while the receiver stays on waits for the next sync-word slot. The host reaches the unit through a small register port. A 4-bit index selects the target: index 0 is the status register for reads and a separate, write-only control register for writes. Indices 1 to 10 are plain storage that stands in for registers outside this unit. Writes to any higher index do nothing, and reads from them return zero.

Two state machines set the interrupt timing. The call gate has three states. CALL_IDLE goes to CALL_WAIT_SYNC when call data is pending, the receiver is on and no status read is taking place. It goes straight to CALL_RELEASED if a sync strobe arrives in that same cycle. CALL_WAIT_SYNC goes to CALL_RELEASED on a sync strobe. Both CALL_WAIT_SYNC and CALL_RELEASED go back to CALL_IDLE on a status read. The interrupt machine has two states. IRQ_QUIET goes to IRQ_RAISED when an enabled source is due and no status read is taking place. IRQ_RAISED goes back to IRQ_QUIET on a status read.

Top module: `pgd_irq_status`

## Requirements
- R1: After reset the status byte reads 0x00 while all level inputs are low. The interrupt output is at its inactive level, and the control register holds 0xFF (every source enabled).
- R2: A pointer-equal pulse (status bit 3), an alert pulse (bit 4), a periodic pulse (bit 7) or any change of the receiver-enable level drives the interrupt active on the second clock edge after the event is sampled, whatever the receiver state.
- R3: Pending call data (bit 2), an out-of-range level change and a battery-low level change activate the interrupt only while the receiver-enable input is low. If they arrive while it is high, they are released when it goes low.
- R4: Call data that becomes pending while the receiver stays enabled activates the interrupt on the second edge after the next sync strobe, and not before.
- R5: A data read at index 0 is a status read. It returns the interrupt output to its inactive level on the next cycle and clears status bits 1, 2, 3, 4 and 7 (bit 1 is set by any pending change of the out-of-range, battery-low or receiver-enable level).
- R6: Status bit 0 shows the receiver-enable level, bit 5 the out-of-range level and bit 6 the battery-low level. These bits follow the live inputs and are not cleared by a status read.
- R7: An event sampled on the same edge as a status read is kept in the status byte. The interrupt goes inactive for one cycle and then becomes active again.
- R8: Control bit n enables the interrupt for the source shown at status bit n (2 call, 3 pointer, 4 alert, 5 out-of-range change, 6 battery-low change, 7 periodic). Bit 0 enables the receiver-enable change and bit 1 the sync-word release of call data. A disabled source still sets its status bit.
- R9: The index register uses only the low 4 bits of the written byte. The upper 4 bits are ignored.
- R10: The control register is write-only and separate from the status register: a write at index 0 does not change what a status read returns.
- R11: Data writes at indices 0xB to 0xF change no register, and data reads from those indices return 0x00.
- R12: The interrupt output is high when active if `irq_pol` is 1, and low when active if `irq_pol` is 0.
- R13: Indices 1 to 10 are read/write byte storage that resets to 0x00 and returns the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_call | input | 1 | Pulse: call data ready |
| ev_ptr | input | 1 | Pulse: memory pointers became equal |
| ev_alert | input | 1 | Pulse: alert time-out expired |
| ev_period | input | 1 | Pulse: periodic time-out expired |
| lvl_oor | input | 1 | Out-of-range indicator level |
| lvl_bat | input | 1 | Battery-low indicator level |
| lvl_rx | input | 1 | Receiver-enable level |
| sync_stb | input | 1 | Pulse: sync-word position |
| irq_pol | input | 1 | Interrupt active level (1 = active high) |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | Host access is a write |
| bus_reg | input | 1 | 0 = index register, 1 = data register |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data for the current index |
| irq_out | output | 1 | Interrupt output |

## Verification
The bench builds the unit with its default parameters: 8-bit data, a 4-bit index, ten storage registers and a control reset value of 0xFF. With these values the whole index space can be reached: storage indices 1 and 10, the first reserved index 0xB, and an index byte with its upper nibble set. With every source enabled at reset, the immediate, receiver-off and sync-slot release paths can each be exercised without setup. Control writes that clear the receiver-change and alert enables then separate the deferred release from the immediate one.

// File: rtl/pgd_irq_pkg.sv
package pgd_irq_pkg;

    localparam int STAT_W = 8;

    // status byte positions
    localparam int S_RXLVL = 0;
    localparam int S_CHG   = 1;
    localparam int S_CALL  = 2;
    localparam int S_PTR   = 3;
    localparam int S_ALERT = 4;
    localparam int S_OOR   = 5;
    localparam int S_BAT   = 6;
    localparam int S_PER   = 7;

    // control (enable) positions
    localparam int E_RXCHG = 0;
    localparam int E_SYNC  = 1;
    localparam int E_CALL  = 2;
    localparam int E_PTR   = 3;
    localparam int E_ALERT = 4;
    localparam int E_OOR   = 5;
    localparam int E_BAT   = 6;
    localparam int E_PER   = 7;

    typedef struct packed {
        logic call;
        logic ptr;
        logic alert;
        logic period;
        logic oor_chg;
        logic bat_chg;
        logic rx_chg;
    } pend_t;

    typedef enum logic [1:0] {
        CALL_IDLE      = 2'd0,
        CALL_WAIT_SYNC = 2'd1,
        CALL_RELEASED  = 2'd2
    } call_state_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_IDX_WR  = 2'd1,
        ACC_DATA_WR = 2'd2,
        ACC_DATA_RD = 2'd3
    } acc_e;

endpackage

// File: rtl/pgd_event_flags.sv
module pgd_event_flags
    import pgd_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ev_call,
    input  logic  ev_ptr,
    input  logic  ev_alert,
    input  logic  ev_period,
    input  logic  lvl_oor,
    input  logic  lvl_bat,
    input  logic  lvl_rx,
    input  logic  clr,
    output pend_t pend
);

    logic oor_prev, bat_prev, rx_prev;
    logic oor_edge, bat_edge, rx_edge;

    assign oor_edge = lvl_oor ^ oor_prev;
    assign bat_edge = lvl_bat ^ bat_prev;
    assign rx_edge  = lvl_rx  ^ rx_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= '0;
            oor_prev <= 1'b0;
            bat_prev <= 1'b0;
            rx_prev  <= 1'b0;
        end else begin
            pend.call    <= (pend.call    & ~clr) | ev_call;
            pend.ptr     <= (pend.ptr     & ~clr) | ev_ptr;
            pend.alert   <= (pend.alert   & ~clr) | ev_alert;
            pend.period  <= (pend.period  & ~clr) | ev_period;
            pend.oor_chg <= (pend.oor_chg & ~clr) | oor_edge;
            pend.bat_chg <= (pend.bat_chg & ~clr) | bat_edge;
            pend.rx_chg  <= (pend.rx_chg  & ~clr) | rx_edge;
            oor_prev     <= lvl_oor;
            bat_prev     <= lvl_bat;
            rx_prev      <= lvl_rx;
        end
    end

    // R7
    keep_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_period |=> pend.period);

    // R5
    clear_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev_ptr) |=> !pend.ptr);

endmodule

// File: rtl/pgd_call_gate.sv
module pgd_call_gate
    import pgd_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic call_pend,
    input  logic rx_on,
    input  logic sync_stb,
    input  logic clr,
    output logic release_o
);

    call_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CALL_IDLE: begin
                if (call_pend && rx_on && !clr)
                    state_d = sync_stb ? CALL_RELEASED : CALL_WAIT_SYNC;
            end
            CALL_WAIT_SYNC: begin
                if (clr)
                    state_d = CALL_IDLE;
                else if (sync_stb)
                    state_d = CALL_RELEASED;
            end
            CALL_RELEASED: begin
                if (clr)
                    state_d = CALL_IDLE;
            end
            default: state_d = CALL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CALL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        release_o = (state_q == CALL_RELEASED);
    end

    // R4
    sync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(release_o) |-> $past(sync_stb));

    // R5
    gate_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !release_o);

endmodule

// File: rtl/pgd_irq_fsm.sv
module pgd_irq_fsm
    import pgd_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic clr,
    input  logic pol,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (trigger && !clr) state_d = IRQ_RAISED;
            IRQ_RAISED: if (clr)             state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED) ? pol : ~pol;
    end

    // R5
    drop_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == IRQ_QUIET));

endmodule

// File: rtl/pgd_host_port.sv
module pgd_host_port
    import pgd_irq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 4,
    parameter int STUB_LAST  = 10,
    parameter logic [DATA_W-1:0] CTRL_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_reg,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              status_rd,
    output logic [DATA_W-1:0] ctrl
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STUB_LAST);

    acc_e              acc;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] stub_q [STUB_LAST];

    always_comb begin
        acc = ACC_NONE;
        if (bus_sel) begin
            unique case ({bus_we, bus_reg})
                2'b10:   acc = ACC_IDX_WR;
                2'b11:   acc = ACC_DATA_WR;
                2'b01:   acc = ACC_DATA_RD;
                default: acc = ACC_NONE;
            endcase
        end
    end

    assign status_rd = (acc == ACC_DATA_RD) && (idx_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            ctrl  <= CTRL_RESET;
            for (int i = 0; i < STUB_LAST; i++) stub_q[i] <= '0;
        end else begin
            if (acc == ACC_IDX_WR)
                idx_q <= bus_wdata[IDX_W-1:0];
            if (acc == ACC_DATA_WR && idx_q == '0)
                ctrl <= bus_wdata;
            for (int i = 0; i < STUB_LAST; i++) begin
                if (acc == ACC_DATA_WR && idx_q == IDX_W'(i + 1))
                    stub_q[i] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (idx_q == '0)
            bus_rdata = status_word;
        for (int i = 0; i < STUB_LAST; i++) begin
            if (idx_q == IDX_W'(i + 1))
                bus_rdata = stub_q[i];
        end
    end

    // R9
    idx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_IDX_WR) |=> (idx_q == $past(bus_wdata[IDX_W-1:0])));

    // R11
    reserved_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q > LAST_IDX) |-> (bus_rdata == '0));

    // R10
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_DATA_WR) |=> $stable(ctrl));

endmodule

// File: rtl/pgd_irq_status.sv
module pgd_irq_status
    import pgd_irq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 4,
    parameter int STUB_LAST = 10,
    parameter logic [DATA_W-1:0] CTRL_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_call,
    input  logic              ev_ptr,
    input  logic              ev_alert,
    input  logic              ev_period,
    input  logic              lvl_oor,
    input  logic              lvl_bat,
    input  logic              lvl_rx,
    input  logic              sync_stb,
    input  logic              irq_pol,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_reg,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    pend_t             pend;
    logic              status_rd;
    logic [DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] status_word;
    logic [STAT_W-1:0] stat8;
    logic              call_rel;
    logic              due_now, due_rx_off, due_sync, trigger;

    pgd_event_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_call   (ev_call),
        .ev_ptr    (ev_ptr),
        .ev_alert  (ev_alert),
        .ev_period (ev_period),
        .lvl_oor   (lvl_oor),
        .lvl_bat   (lvl_bat),
        .lvl_rx    (lvl_rx),
        .clr       (status_rd),
        .pend      (pend)
    );

    pgd_call_gate u_call (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_pend (pend.call),
        .rx_on     (lvl_rx),
        .sync_stb  (sync_stb),
        .clr       (status_rd),
        .release_o (call_rel)
    );

    always_comb begin
        stat8          = '0;
        stat8[S_RXLVL] = lvl_rx;
        stat8[S_CHG]   = pend.oor_chg | pend.bat_chg | pend.rx_chg;
        stat8[S_CALL]  = pend.call;
        stat8[S_PTR]   = pend.ptr;
        stat8[S_ALERT] = pend.alert;
        stat8[S_OOR]   = lvl_oor;
        stat8[S_BAT]   = lvl_bat;
        stat8[S_PER]   = pend.period;
        status_word    = DATA_W'(stat8);
    end

    always_comb begin
        due_now    = (pend.ptr    & ctrl[E_PTR])
                   | (pend.alert  & ctrl[E_ALERT])
                   | (pend.period & ctrl[E_PER])
                   | (pend.rx_chg & ctrl[E_RXCHG]);
        due_rx_off = ~lvl_rx & ((pend.call    & ctrl[E_CALL])
                              | (pend.oor_chg & ctrl[E_OOR])
                              | (pend.bat_chg & ctrl[E_BAT]));
        due_sync   = call_rel & ctrl[E_CALL] & ctrl[E_SYNC];
        trigger    = due_now | due_rx_off | due_sync;
    end

    pgd_host_port #(
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W),
        .STUB_LAST  (STUB_LAST),
        .CTRL_RESET (CTRL_RESET)
    ) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_reg     (bus_reg),
        .bus_wdata   (bus_wdata),
        .status_word (status_word),
        .bus_rdata   (bus_rdata),
        .status_rd   (status_rd),
        .ctrl        (ctrl)
    );

    pgd_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (trigger),
        .clr     (status_rd),
        .pol     (irq_pol),
        .irq_o   (irq_out)
    );

    // R2
    immediate_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.ptr && ctrl[E_PTR] && !status_rd) |=> (irq_out == irq_pol));

    // R12
    inactive_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> (irq_out != irq_pol));

    // R3
    deferred_bat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.bat_chg && ctrl[E_BAT] && !lvl_rx && !status_rd) |=> (irq_out == irq_pol));

endmodule

// File: tb/pgd_irq_status_test.sv
module pgd_irq_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_call = 0, ev_ptr = 0, ev_alert = 0, ev_period = 0;
    logic       lvl_oor = 0, lvl_bat = 0, lvl_rx = 0, sync_stb = 0;
    logic       irq_pol = 1'b1;
    logic       bus_sel = 0, bus_we = 0, bus_reg = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       mon_ev;

    localparam int K_CALL = 0, K_PTR = 1, K_ALERT = 2, K_PER = 3, K_SYNC = 4;

    always #10 clk = ~clk;

    pgd_irq_status uut (
        .clk(clk), .rst_n(rst_n),
        .ev_call(ev_call), .ev_ptr(ev_ptr), .ev_alert(ev_alert), .ev_period(ev_period),
        .lvl_oor(lvl_oor), .lvl_bat(lvl_bat), .lvl_rx(lvl_rx), .sync_stb(sync_stb),
        .irq_pol(irq_pol), .bus_sel(bus_sel), .bus_we(bus_we), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(string tag, bit active);
        chk(tag, {7'd0, irq_out}, {7'd0, active ? irq_pol : ~irq_pol});
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(bit r, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_reg = r; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(logic [7:0] idx, logic [7:0] exp, string tag, bit with_period = 0);
        bus_wr(0, idx);
        bus_sel = 1; bus_we = 0; bus_reg = 1; ev_period = with_period;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        #5 -> mon_ev;
        @(negedge clk);
        bus_sel = 0; ev_period = 0;
    endtask

    task automatic pulse(int k);
        @(negedge clk);
        case (k)
            K_CALL:  ev_call = 1;
            K_PTR:   ev_ptr = 1;
            K_ALERT: ev_alert = 1;
            K_PER:   ev_period = 1;
            default: sync_stb = 1;
        endcase
        @(negedge clk);
        ev_call = 0; ev_ptr = 0; ev_alert = 0; ev_period = 0; sync_stb = 0;
    endtask

    task automatic set_ctrl(logic [7:0] v);
        bus_wr(0, 8'h00);
        bus_wr(1, v);
    endtask

    // monitor: pops expected read data and compares
    initial begin
        forever begin
            @(mon_ev);
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);

        // R1 reset state
        chk_irq("R1 irq inactive", 0);
        rd(8'h00, 8'h00, "R1 status after reset");
        rd(8'h05, 8'h00, "R13 storage reset");

        // R2 pointer-equal immediate
        pulse(K_PTR); step(1);
        chk_irq("R2 ptr irq", 1);
        rd(8'h00, 8'h08, "R5 ptr status");
        chk_irq("R5 irq cleared", 0);
        rd(8'h00, 8'h00, "R5 bits cleared");

        // R2 alert immediate
        pulse(K_ALERT); step(1);
        chk_irq("R2 alert irq", 1);
        rd(8'h00, 8'h10, "R2 alert status");
        chk_irq("R5 irq cleared alert", 0);

        // R2 receiver-enable change immediate
        @(negedge clk); lvl_rx = 1;
        step(2);
        chk_irq("R2 rx change irq", 1);
        rd(8'h00, 8'h03, "R6 rx level and change");
        chk_irq("R5 irq cleared rx", 0);

        // R4 call waits for sync while receiver on
        pulse(K_CALL); step(3);
        chk_irq("R4 call held", 0);
        pulse(K_SYNC); step(1);
        chk_irq("R4 call at sync", 1);
        rd(8'h00, 8'h05, "R4 call status");
        chk_irq("R5 irq cleared call", 0);

        // R3 battery change deferred until receiver off (rx change disabled, R8)
        set_ctrl(8'hFE);
        @(negedge clk); lvl_bat = 1;
        step(4);
        chk_irq("R3 bat held while rx on", 0);
        @(negedge clk); lvl_rx = 0;
        step(2);
        chk_irq("R3 bat released rx off", 1);
        rd(8'h00, 8'h42, "R6 bat level status");
        chk_irq("R5 irq cleared bat", 0);
        rd(8'h00, 8'h40, "R6 level kept after read");

        // R8 disabled alert still latches
        set_ctrl(8'hEE);
        pulse(K_ALERT); step(3);
        chk_irq("R8 alert masked", 0);
        rd(8'h00, 8'h50, "R8 alert latched");
        set_ctrl(8'hFF);

        // R7 event in the same cycle as the status read
        rd(8'h00, 8'h40, "R7 read with event", 1);
        chk_irq("R7 inactive after read", 0);
        step(1);
        chk_irq("R7 reasserted", 1);
        rd(8'h00, 8'hC0, "R7 event kept");
        chk_irq("R7 cleared", 0);

        // R10 control write does not alter status
        set_ctrl(8'h55);
        rd(8'h00, 8'h40, "R10 status independent of control");
        pulse(K_PTR); step(3);
        chk_irq("R10 ptr disabled by control", 0);
        rd(8'h00, 8'h48, "R10 ptr latched");
        set_ctrl(8'hFF);

        // R12 polarity
        @(negedge clk); irq_pol = 0;
        step(1);
        chk_irq("R12 idle high when active low", 0);
        chk("R12 idle level", {7'd0, irq_out}, 8'h01);
        pulse(K_PTR); step(1);
        chk("R12 active low level", {7'd0, irq_out}, 8'h00);
        rd(8'h00, 8'h48, "R12 status");
        chk("R12 back to idle", {7'd0, irq_out}, 8'h01);
        @(negedge clk); irq_pol = 1;

        // R3 out-of-range change with receiver already off
        @(negedge clk); lvl_oor = 1;
        step(2);
        chk_irq("R3 oor with rx off", 1);
        rd(8'h00, 8'h62, "R6 oor level status");
        chk_irq("R5 irq cleared oor", 0);

        // R9 upper index bits ignored, R13 storage
        bus_wr(0, 8'h13);
        bus_wr(1, 8'h5A);
        rd(8'hF3, 8'h5A, "R9 upper nibble ignored");
        rd(8'h03, 8'h5A, "R13 storage 3");
        bus_wr(0, 8'h0A);
        bus_wr(1, 8'hA5);
        rd(8'h0A, 8'hA5, "R13 storage 10");

        // R11 reserved indices
        bus_wr(0, 8'h0B);
        bus_wr(1, 8'h77);
        bus_wr(0, 8'h0F);
        bus_wr(1, 8'h00);
        rd(8'h0B, 8'h00, "R11 reserved read zero");
        rd(8'h0A, 8'hA5, "R11 storage 10 untouched");
        rd(8'h03, 8'h5A, "R11 storage 3 untouched");
        rd(8'h00, 8'h60, "R11 status untouched");
        pulse(K_PTR); step(1);
        chk_irq("R11 control untouched", 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule